// File: doc/BRIEF.md
# Electrode Offset Servo Integrator

This block produces the 12-bit code for one channel's offset-cancelling DAC. In servo mode it integrates the 1-bit sigma-delta modulator stream. Each modulator sample moves a wide fixed-point accumulator up or down by a programmable step. The integer part of the accumulator drives the DAC, which closes a slow loop that pushes the electrode DC offset toward zero. In manual mode the DAC follows a code written by configuration software. The integrator is held at that code so that a later change to servo mode does not cause a jump.

The time constant is set by a 4-bit shift `tc_shift`. Each counted modulator sample changes the accumulator by 2^(16 - tc_shift) units, and the accumulator carries 16 fractional bits. A shift of 0 therefore moves the DAC by one code per sample. A shift of 15 needs 32768 samples per code, which gives settling times on the order of a second at kilohertz sample rates.

A three-state sequencer controls the mode. Its states are MANUAL, ARM and TRACK. The transitions are:
- MANUAL to ARM when `sel_auto` is sampled high.
- ARM to TRACK when `sel_auto` stays high.
- ARM to MANUAL when `sel_auto` drops.
- TRACK to MANUAL when `sel_auto` is sampled low.

In MANUAL and ARM the accumulator is reloaded from the manual code on every clock.

Top module: `offset_servo`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dac_code` equals `manual_code`. The accumulator is loaded with that code and the sequencer is in MANUAL.
- R2: Outside TRACK, `dac_code` takes the value `manual_code` had at the previous rising edge. Modulator strobes then have no effect on it.
- R3: In TRACK, a strobe (`mod_strobe`=1) with `mod_bit`=1 raises the accumulator by one step, and one with `mod_bit`=0 lowers it by one step. `dac_code` shows the new integer part (accumulator bits 27:16) at the same edge.
- R4: The step is 2^(16 - `tc_shift`) fractional units. With `tc_shift`=0 each strobe moves `dac_code` by 1. With `tc_shift`=4 sixteen strobes are needed per code.
- R5: In TRACK, cycles without `mod_strobe` leave the accumulator and `dac_code` unchanged, whatever `mod_bit` is.
- R6: The accumulator saturates. Upward steps stop at code 4095 with all fractional bits set, and downward steps stop at 0. It never wraps.
- R7: Servo mode is entered through ARM. The accumulator is reloaded from `manual_code` at the edge that first samples `sel_auto` high and again at the next edge. Strobes at those two edges are not counted, and the first TRACK code equals the manual code.
- R8: When `sel_auto` is sampled low in TRACK, the sequencer returns to MANUAL. `dac_code` equals `manual_code` from the second edge on.
- R9: If the bitstream is 1 whenever `dac_code` is below an offset value and 0 otherwise, the servo settles and then stays within one code of that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_auto | input | 1 | 1 = servo (integrator) source, 0 = manual code source |
| manual_code | input | 12 | Configuration-written DAC code |
| tc_shift | input | 4 | Time-constant shift; step = 2^(16 - tc_shift) |
| mod_strobe | input | 1 | Modulator sample valid |
| mod_bit | input | 1 | Modulator output bit (1 = raise code) |
| dac_code | output | 12 | Registered DAC code |

## Verification
A counted strobe appears in `dac_code` at the same rising edge that samples it. The bench therefore drives each strobe at a falling edge and checks at the next falling edge. Changes to `manual_code` also take one edge. Mode changes take two edges through ARM, or two edges back to MANUAL, so the entry and exit tasks wait two falling edges before they check. The closed-loop test computes each bit from the code observed one half cycle earlier. This models the plant without any look into the design.

// File: rtl/osrv_pkg.sv
package osrv_pkg;
    typedef enum logic [1:0] {
        SV_MANUAL = 2'd0,
        SV_ARM    = 2'd1,
        SV_TRACK  = 2'd2
    } srv_state_t;
endpackage

// File: rtl/osrv_mode_fsm.sv
module osrv_mode_fsm
    import osrv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_auto,
    output logic preload,
    output logic track
);
    srv_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SV_MANUAL;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_MANUAL: if (sel_auto)  state_d = SV_ARM;
            SV_ARM:    state_d = sel_auto ? SV_TRACK : SV_MANUAL;
            SV_TRACK:  if (!sel_auto) state_d = SV_MANUAL;
            default:   state_d = SV_MANUAL;
        endcase
    end

    // outputs
    always_comb begin
        preload = 1'b1;
        track   = 1'b0;
        unique case (state_q)
            SV_MANUAL, SV_ARM: begin preload = 1'b1; track = 1'b0; end
            SV_TRACK:          begin preload = 1'b0; track = 1'b1; end
            default:           begin preload = 1'b1; track = 1'b0; end
        endcase
    end

    // R7: servo entry always passes through ARM from MANUAL
    p_arm_from_manual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SV_ARM) |-> ($past(state_q) == SV_MANUAL));

    // R8: TRACK is only held while the select was high
    p_track_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SV_TRACK) |-> $past(sel_auto));
endmodule

// File: rtl/osrv_accum.sv
module osrv_accum #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 16,
    parameter int SH_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [INT_W-1:0] load_val,
    input  logic             step_en,
    input  logic             step_up,
    input  logic [SH_W-1:0]  shift,
    output logic [INT_W-1:0] acc_nxt_int
);
    localparam int ACC_W = INT_W + FRAC_W;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    logic [ACC_W-1:0] acc_q, acc_d, step, dn_sat, up_sat;
    logic [ACC_W:0]   up_sum;

    always_comb begin
        if (int'(shift) >= FRAC_W) step = ONE;
        else                       step = ONE << (FRAC_W - int'(shift));
    end

    always_comb begin
        up_sum = {1'b0, acc_q} + {1'b0, step};
        up_sat = up_sum[ACC_W] ? ACC_MAX : up_sum[ACC_W-1:0];
        dn_sat = (acc_q < step) ? '0 : (acc_q - step);
        if (load)         acc_d = {load_val, {FRAC_W{1'b0}}};
        else if (step_en) acc_d = step_up ? up_sat : dn_sat;
        else              acc_d = acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= {load_val, {FRAC_W{1'b0}}};
        else        acc_q <= acc_d;
    end

    assign acc_nxt_int = acc_d[ACC_W-1:FRAC_W];

    // R5: no strobe, no load -> accumulator holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(acc_q));

    // R6: saturation at both ends
    p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && step_up && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && !step_up && acc_q == '0) |=> (acc_q == '0));

    // R4: unsaturated upward step adds exactly one step
    p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && step_up && (acc_q <= ACC_MAX - step))
        |=> (acc_q == $past(acc_q + step)));
endmodule

// File: rtl/offset_servo.sv
module offset_servo #(
    parameter int DAC_W  = 12,
    parameter int FRAC_W = 16,
    parameter int SH_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_auto,
    input  logic [DAC_W-1:0] manual_code,
    input  logic [SH_W-1:0]  tc_shift,
    input  logic             mod_strobe,
    input  logic             mod_bit,
    output logic [DAC_W-1:0] dac_code
);
    logic             preload, track;
    logic [DAC_W-1:0] nxt_int;

    osrv_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_auto (sel_auto),
        .preload  (preload),
        .track    (track)
    );

    osrv_accum #(.INT_W(DAC_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (preload),
        .load_val    (manual_code),
        .step_en     (track & mod_strobe),
        .step_up     (mod_bit),
        .shift       (tc_shift),
        .acc_nxt_int (nxt_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     dac_code <= manual_code;
        else if (track) dac_code <= nxt_int;
        else            dac_code <= manual_code;
    end

    // R2: outside TRACK the DAC follows the configured code one edge later
    p_manual_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!track) |=> (dac_code == $past(manual_code)));

    // R5: in TRACK with no strobe the DAC code is held
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (track && !mod_strobe) |=> $stable(dac_code));
endmodule

// File: tb/sim_offset_servo.sv
module sim_offset_servo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_auto = 1'b0;
    logic [11:0] manual_code = 12'd0;
    logic [3:0]  tc_shift = 4'd0;
    logic        mod_strobe = 1'b0;
    logic        mod_bit = 1'b0;
    logic [11:0] dac_code;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    offset_servo u0 (
        .clk(clk), .rst_n(rst_n), .sel_auto(sel_auto), .manual_code(manual_code),
        .tc_shift(tc_shift), .mod_strobe(mod_strobe), .mod_bit(mod_bit),
        .dac_code(dac_code)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic strobe(input logic b);
        mod_strobe = 1'b1; mod_bit = b;
        @(negedge clk);
        mod_strobe = 1'b0;
    endtask

    task automatic go_auto();
        sel_auto = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic go_manual();
        sel_auto = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; manual_code = 12'd1234;
        repeat (3) @(negedge clk);
        check("R1 in reset", dac_code, 1234);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", dac_code, 1234);
    endtask

    task automatic t_manual();
        manual_code = 12'd777;
        @(negedge clk);
        check("R2 follow", dac_code, 777);
        for (int i = 0; i < 4; i++) strobe(1'b1);
        check("R2 strobes ignored", dac_code, 777);
    endtask

    task automatic t_auto_unit();
        manual_code = 12'd500; tc_shift = 4'd0;
        @(negedge clk);
        mod_strobe = 1'b1; mod_bit = 1'b1;
        go_auto();
        mod_strobe = 1'b0;
        check("R7 preload, arm strobes ignored", dac_code, 500);
        strobe(1'b1); strobe(1'b1);
        check("R3 up steps", dac_code, 502);
        strobe(1'b0); strobe(1'b0); strobe(1'b0);
        check("R3 down steps", dac_code, 499);
        for (int i = 0; i < 6; i++) begin mod_bit = i[0]; @(negedge clk); end
        check("R5 no strobe hold", dac_code, 499);
        go_manual();
        check("R8 back to manual", dac_code, 500);
    endtask

    task automatic t_timeconst();
        manual_code = 12'd100; tc_shift = 4'd4;
        @(negedge clk);
        go_auto();
        for (int i = 0; i < 15; i++) strobe(1'b1);
        check("R4 15 strobes below one code", dac_code, 100);
        strobe(1'b1);
        check("R4 16th strobe", dac_code, 101);
        go_manual();
        tc_shift = 4'd0;
    endtask

    task automatic t_saturation();
        manual_code = 12'd4094;
        @(negedge clk);
        go_auto();
        strobe(1'b1); strobe(1'b1); strobe(1'b1);
        check("R6 ceiling", dac_code, 4095);
        strobe(1'b0);
        check("R6 no wrap after ceiling", dac_code, 4094);
        go_manual();
        manual_code = 12'd1;
        @(negedge clk);
        go_auto();
        strobe(1'b0); strobe(1'b0); strobe(1'b0);
        check("R6 floor", dac_code, 0);
        strobe(1'b1);
        check("R6 no wrap after floor", dac_code, 1);
        go_manual();
    endtask

    task automatic t_reentry();
        manual_code = 12'd3000;
        @(negedge clk);
        go_auto();
        strobe(1'b1);
        check("R3 step from new preload", dac_code, 3001);
        sel_auto = 1'b0; manual_code = 12'd42;
        @(negedge clk);
        check("R8 first edge still servo path", dac_code, 3001);
        @(negedge clk);
        check("R8 manual code restored", dac_code, 42);
        go_auto();
        check("R7 re-entry preloads new code", dac_code, 42);
        go_manual();
    endtask

    task automatic t_loop(input int start, input int target, input int sh);
        int d;
        manual_code = 12'(start); tc_shift = 4'(sh);
        @(negedge clk);
        go_auto();
        for (int i = 0; i < 1500; i++) strobe(int'(dac_code) < target);
        d = int'(dac_code) - target;
        if (d < 0) d = -d;
        check("R9 settled within one code", (d <= 1) ? 1 : 0, 1);
        go_manual();
        tc_shift = 4'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_manual();
        t_auto_unit();
        t_timeconst();
        t_saturation();
        t_reentry();
        t_loop(2000, 2600, 0);
        t_loop(900, 600, 1);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule